// File: doc/BRIEF.md
# Fixed-Page Stack Pointer Unit

This unit owns the 8-bit stack pointer of a small processor whose stack lives in one fixed 256-byte memory page. Every stack address is formed from a constant page byte (0x01 by default) in the upper half and the pointer in the lower half, so the stack always stays inside 0x0100..0x01FF. The unit serves six stack operations: it pushes and pulls the accumulator and the status byte, and it saves and restores a 16-bit return address for subroutine call and return. A 16-bit return address is moved as two byte-wide transfers.

A requester hands over one operation at a time on a valid/ready request channel. The unit then drives the memory port with one access per cycle, either a write strobe with data or a read whose data returns in the same cycle, and moves the pointer. It signals completion on a valid/ready response channel that carries any pulled bytes. Back-pressure: a request is taken only on a cycle where `req_valid` and `req_ready` are both high. The payload must be valid on that cycle. `rsp_valid` stays high with `rsp_data` unchanged until `rsp_ready` is seen high, and the unit accepts no new request before then. A plain load input lets software set the pointer, and `sp_value` always shows the pointer.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset the pointer reads 0xFF, `req_ready` is 1, and `rsp_valid` and `mem_we` are 0.
- R2: Every stack access drives `mem_addr` with 0x01 as the high byte. The low byte is the pointer for a write and the pointer plus one (mod 256) for a read.
- R3: A push beat writes its byte at 0x0100+pointer with `mem_we`=1, and the pointer then drops by one.
- R4: A pull beat raises the pointer by one and reads from 0x0100 plus the new pointer. For a single-byte pull the byte appears in `rsp_data[7:0]` and `rsp_data[15:8]` is 0.
- R5: A call (code 4) makes two consecutive write beats, the return-address high byte first and the low byte second. The pointer ends two lower.
- R6: A return (code 5) makes two consecutive read beats. The first byte read goes to `rsp_data[7:0]` and the second to `rsp_data[15:8]`. The pointer ends two higher.
- R7: The pointer wraps modulo 256: a push at 0x00 leaves 0xFF, and a pull at 0xFF reads 0x0100 and leaves 0x00.
- R8: `req_ready` is 1 only while idle with `sp_load` low. The first memory beat happens in the cycle after acceptance and further beats follow with no gaps.
- R9: In the cycle after the last beat, `rsp_valid` rises. It holds with stable `rsp_data` until `rsp_ready`, and push operations respond with `rsp_data`=0.
- R10: `sp_load` while idle sets the pointer to `sp_load_val` at the next edge and blocks acceptance in that cycle. While an operation is in flight or awaiting response, `sp_load` has no effect on the pointer.
- R11: Operation codes are as follows. 0 pushes `acc_in` and 1 pushes `psr_in`. 2 pulls into the accumulator lane and 3 pulls into the status lane. 4 is call, with `pc_in` as the return address, and 5 is return. Codes 6 and 7 make no memory access, leave the pointer unchanged, and respond with 0 in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_op | input | 3 | Operation code (R11) |
| acc_in | input | 8 | Accumulator byte to push |
| psr_in | input | 8 | Status byte to push |
| pc_in | input | 16 | Return address for a call |
| sp_load | input | 1 | Load pointer when idle |
| sp_load_val | input | 8 | Value to load |
| sp_value | output | 8 | Current pointer |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the same cycle |
| rsp_valid | output | 1 | Operation complete |
| rsp_ready | input | 1 | Response taken |
| rsp_data | output | 16 | Pulled bytes, 0 for pushes |

## Verification
Directed sequences nest a call and return around pushes and pulls of both one-byte registers. This separates the byte order of the return address from the ordering of single-byte entries, and it shows whether write and read addresses are offset by one. Loads to 0x00 and 0xFF followed by a push or pull tell modulo wrap apart from page escape. A held-low `rsp_ready` shows whether the response is stable and acceptance is blocked. Long free-running random traffic then mixes illegal codes, loads issued while busy, and random back-pressure against a per-cycle reference model. That traffic separates correct gating of `sp_load` from loads that leak into busy cycles.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam logic [2:0] OP_PUSH_ACC = 3'd0;
  localparam logic [2:0] OP_PUSH_PSR = 3'd1;
  localparam logic [2:0] OP_PULL_ACC = 3'd2;
  localparam logic [2:0] OP_PULL_PSR = 3'd3;
  localparam logic [2:0] OP_CALL     = 3'd4;
  localparam logic [2:0] OP_RET      = 3'd5;

  typedef enum logic [1:0] {ST_IDLE, ST_BEAT, ST_RESP} seq_state_e;

  function automatic logic [1:0] op_beats(input logic [2:0] op);
    case (op)
      OP_PUSH_ACC, OP_PUSH_PSR, OP_PULL_ACC, OP_PULL_PSR: op_beats = 2'd1;
      OP_CALL, OP_RET: op_beats = 2'd2;
      default: op_beats = 2'd0;
    endcase
  endfunction

  function automatic logic op_writes(input logic [2:0] op);
    op_writes = (op == OP_PUSH_ACC) || (op == OP_PUSH_PSR) || (op == OP_CALL);
  endfunction
endpackage

// File: rtl/stk_ptr_reg.sv
module stk_ptr_reg #(
  parameter int PW = 8,
  parameter logic [PW-1:0] RST_VAL = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] load_val,
  input  logic          step_up,
  input  logic          step_dn,
  output logic [PW-1:0] sp,
  output logic [PW-1:0] sp_plus1
);
  always_ff @(posedge clk) begin
    if (!rst_n)       sp <= RST_VAL;
    else if (load)    sp <= load_val;
    else if (step_up) sp <= sp + 1'b1;
    else if (step_dn) sp <= sp - 1'b1;
  end

  assign sp_plus1 = sp + 1'b1;

  // R7
  wrap_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp == '0 && step_dn && !load && !step_up) |=> (sp == '1));
  // R7
  wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp == '1 && step_up && !load) |=> (sp == '0));
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [2:0] req_op,
  input  logic       hold,
  input  logic       rsp_ready,
  output logic       req_ready,
  output logic       accept,
  output logic       idle,
  output logic       beat_active,
  output logic [0:0] beat_idx,
  output logic [2:0] op_q,
  output logic       rsp_valid
);
  seq_state_e state;
  logic [1:0] nbeats;

  assign idle        = (state == ST_IDLE);
  assign req_ready   = idle && !hold;
  assign accept      = req_valid && req_ready;
  assign beat_active = (state == ST_BEAT);
  assign rsp_valid   = (state == ST_RESP);
  assign nbeats      = op_beats(op_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      op_q     <= '0;
      beat_idx <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          op_q     <= req_op;
          beat_idx <= '0;
          state    <= (op_beats(req_op) == 2'd0) ? ST_RESP : ST_BEAT;
        end
        ST_BEAT: begin
          beat_idx <= beat_idx + 1'b1;
          if ({1'b0, beat_idx} == nbeats - 2'd1) state <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  // R8
  beat_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_beats(req_op) != 2'd0) |=> beat_active);
endmodule

// File: rtl/stk_collect.sv
module stk_collect #(
  parameter int DW = 8,
  parameter int LANES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   capture,
  input  logic [$clog2(LANES)-1:0] lane,
  input  logic [DW-1:0]          din,
  output logic [DW*LANES-1:0]    dout
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n || clear)                   dout[g*DW +: DW] <= '0;
      else if (capture && lane == g)         dout[g*DW +: DW] <= din;
    end
  end
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
  import stk_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16,
  parameter logic [AW-DW-1:0] STACK_PAGE = 'h01,
  parameter logic [DW-1:0] SP_RESET = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic [DW-1:0] acc_in,
  input  logic [DW-1:0] psr_in,
  input  logic [AW-1:0] pc_in,
  input  logic          sp_load,
  input  logic [DW-1:0] sp_load_val,
  output logic [DW-1:0] sp_value,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [AW-1:0] rsp_data
);
  localparam int LANES = AW / DW;

  logic          accept, idle, beat_active;
  logic [0:0]    beat_idx;
  logic [2:0]    op_q;
  logic          wr_op, step_up, step_dn, ld_en;
  logic [DW-1:0] sp_plus1;
  logic [DW-1:0] acc_q, psr_q;
  logic [AW-1:0] pc_q;

  stk_seq u_seq (
    .clk, .rst_n, .req_valid, .req_op, .hold(sp_load), .rsp_ready,
    .req_ready, .accept, .idle, .beat_active, .beat_idx, .op_q, .rsp_valid
  );

  assign wr_op   = op_writes(op_q);
  assign step_dn = beat_active && wr_op;
  assign step_up = beat_active && !wr_op;
  assign ld_en   = sp_load && idle;

  stk_ptr_reg #(.PW(DW), .RST_VAL(SP_RESET)) u_ptr (
    .clk, .rst_n, .load(ld_en), .load_val(sp_load_val),
    .step_up, .step_dn, .sp(sp_value), .sp_plus1
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0; psr_q <= '0; pc_q <= '0;
    end else if (accept) begin
      acc_q <= acc_in; psr_q <= psr_in; pc_q <= pc_in;
    end
  end

  always_comb begin
    case (op_q)
      OP_PUSH_ACC: mem_wdata = acc_q;
      OP_PUSH_PSR: mem_wdata = psr_q;
      OP_CALL:     mem_wdata = pc_q[(LANES-1-int'(beat_idx))*DW +: DW];
      default:     mem_wdata = '0;
    endcase
  end

  assign mem_we   = step_dn;
  assign mem_addr = {STACK_PAGE, (step_up ? sp_plus1 : sp_value)};

  stk_collect #(.DW(DW), .LANES(LANES)) u_col (
    .clk, .rst_n, .clear(accept), .capture(step_up), .lane(beat_idx),
    .din(mem_rdata), .dout(rsp_data)
  );

  // R3
  push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (sp_value == DW'($past(mem_addr[DW-1:0]) - 1'b1)));
  // R4
  pull_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_up |=> (sp_value == $past(mem_addr[DW-1:0])));
  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  // R10
  load_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid) |=> $stable(sp_value));
endmodule

// File: tb/tb_stack_ptr_unit.sv
module tb_stack_ptr_unit;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, sp_load = 0, rsp_ready = 0;
  logic [2:0] req_op = 0;
  logic [7:0] acc_in = 0, psr_in = 0, sp_load_val = 0;
  logic [15:0] pc_in = 0;
  logic req_ready, mem_we, rsp_valid;
  logic [7:0] sp_value, mem_wdata, mem_rdata;
  logic [15:0] mem_addr, rsp_data;

  int nchk = 0, nerr = 0;
  logic [7:0] ram [256];

  stack_ptr_unit dut (.*);

  always #5ns clk = ~clk;

  assign mem_rdata = ram[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_st = 0, m_beat = 0, m_nb = 0, m_op = 0;
  logic [7:0] m_sp = 8'hFF, m_acc, m_psr;
  logic [15:0] m_pc, m_data;
  logic [7:0] m_page [256];

  function automatic int nb(int op);
    return (op < 4) ? 1 : (op < 6) ? 2 : 0;
  endfunction
  function automatic bit wr(int op);
    return op == 0 || op == 1 || op == 4;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_sp = 8'hFF;
    end else begin
      case (m_st)
        0: if (sp_load) m_sp = sp_load_val;
           else if (req_valid) begin
             m_op = req_op; m_acc = acc_in; m_psr = psr_in; m_pc = pc_in;
             m_data = 0; m_beat = 0; m_nb = nb(m_op);
             m_st = (m_nb == 0) ? 2 : 1;
           end
        1: begin
          if (wr(m_op)) begin
            m_page[m_sp] = (m_op == 0) ? m_acc : (m_op == 1) ? m_psr :
                           (m_beat == 0) ? m_pc[15:8] : m_pc[7:0];
            m_sp = m_sp - 1;
          end else begin
            m_sp = m_sp + 1;
            if (m_beat == 0) m_data[7:0] = m_page[m_sp];
            else m_data[15:8] = m_page[m_sp];
          end
          m_beat++;
          if (m_beat == m_nb) m_st = 2;
        end
        default: if (rsp_ready) m_st = 0;
      endcase
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk("R10", sp_value, m_sp, "pointer");
    chk("R8", req_ready, (m_st == 0) && !sp_load, "req_ready");
    chk("R9", rsp_valid, m_st == 2, "rsp_valid");
    chk("R3", mem_we, (m_st == 1) && wr(m_op), "mem_we");
    if (m_st == 1) begin
      chk("R2", mem_addr, {8'h01, wr(m_op) ? m_sp : 8'(m_sp + 1)}, "mem_addr");
      if (wr(m_op))
        chk("R5", mem_wdata, (m_op == 0) ? m_acc : (m_op == 1) ? m_psr :
                             (m_beat == 0) ? m_pc[15:8] : m_pc[7:0], "mem_wdata");
    end
    if (m_st == 2) chk("R6", rsp_data, m_data, "rsp_data");
  end

  logic [15:0] last_rsp;

  task automatic do_op(input logic [2:0] op, input logic [7:0] a, input logic [7:0] p,
                       input logic [15:0] pc);
    bit got;
    req_valid = 1; req_op = op; acc_in = a; psr_in = p; pc_in = pc; rsp_ready = 1;
    do begin @(negedge clk); got = req_ready; @(posedge clk); #1; end while (!got);
    req_valid = 0;
    do @(negedge clk); while (!rsp_valid);
    last_rsp = rsp_data;
    @(posedge clk); #1;
  endtask

  task automatic load_sp(input logic [7:0] v);
    sp_load = 1; sp_load_val = v; @(posedge clk); #1; sp_load = 0;
  endtask

  initial begin
    #2_000_000ns;
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin ram[i] = 0; m_page[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1", {sp_value, req_ready, rsp_valid, mem_we}, {8'hFF, 3'b100}, "reset state");
    @(posedge clk); #1;

    do_op(0, 8'h11, 0, 0);            // R3 push acc
    chk("R3", sp_value, 8'hFE, "sp after push");
    do_op(1, 0, 8'h22, 0);
    do_op(4, 0, 0, 16'hABCD);         // R5 call
    chk("R5", sp_value, 8'hFB, "sp after call");
    chk("R5", {ram[8'hFD], ram[8'hFC]}, 16'hABCD, "call byte order");
    do_op(5, 0, 0, 0);                // R6 return
    chk("R6", last_rsp, 16'hABCD, "return value");
    do_op(3, 0, 0, 0);
    chk("R4", last_rsp, 16'h0022, "pull status");
    do_op(2, 0, 0, 0);
    chk("R4", last_rsp, 16'h0011, "pull acc");
    chk("R4", sp_value, 8'hFF, "sp after pulls");

    load_sp(8'h00);
    chk("R10", sp_value, 8'h00, "load while idle");
    do_op(0, 8'h5A, 0, 0);
    chk("R7", sp_value, 8'hFF, "wrap on push");
    chk("R7", ram[8'h00], 8'h5A, "written at 0x0100");
    do_op(2, 0, 0, 0);
    chk("R7", last_rsp, 16'h005A, "wrap on pull");
    chk("R7", sp_value, 8'h00, "sp after wrap pull");

    do_op(6, 0, 0, 0);
    chk("R11", {last_rsp, sp_value}, 24'h000000, "illegal code");

    // back-pressure: response held, sp_load ignored while responding
    req_valid = 1; req_op = 0; acc_in = 8'h77; rsp_ready = 0;
    @(posedge clk); #1; req_valid = 0;
    repeat (3) @(posedge clk);
    #1 sp_load = 1; sp_load_val = 8'h40;
    @(negedge clk);
    chk("R9", {rsp_valid, req_ready}, 2'b10, "held response");
    @(posedge clk); #1 sp_load = 0;
    chk("R10", sp_value, 8'hFF, "load ignored while responding");
    rsp_ready = 1; @(posedge clk); #1;

    // random traffic against the model
    repeat (4000) begin
      req_valid = ($urandom % 3) != 0;
      req_op = 3'($urandom);
      acc_in = 8'($urandom); psr_in = 8'($urandom); pc_in = 16'($urandom);
      sp_load = ($urandom % 12) == 0; sp_load_val = 8'($urandom);
      rsp_ready = ($urandom % 3) != 0;
      @(posedge clk); #1;
    end
    req_valid = 0; sp_load = 0;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule